// File: doc/BRIEF.md
# I2C Slave Byte Engine with Host-Paced Clock Stretching

This block is the target side of a two-wire serial bus. It watches the clock and data lines for START and STOP, shifts in a 7-bit device address and compares it with a fixed own address. On a match it acknowledges, takes its transfer direction from the read/write bit, and then moves data one byte at a time, either from the master or to the master. Both lines are driven only through open-drain enables: a 1 on an enable pulls that line low.

The block does not buffer data. After the ninth clock of every byte it handles, it holds the clock line low and raises an interrupt flag. The host CPU then services the byte through a small register file, and the clock is released only by the access that fits the current direction. In transmit direction that access is a write of the data register. In receive direction it is a read of the data register. When the master ends a read with a not-acknowledge, the host switches the direction bit to receive and does a dummy read. That read frees the clock so the master can send STOP.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset both enables `scl_oe_o` and `sda_oe_o` are 0, `irq_o` is 0, the status register (host address 2) reads 0 and the control register (host address 1) reads 0.
- R2: An address byte is sent MSB first: 7 address bits, then a read/write bit (1 means the master reads). If the seven bits equal `OWN_ADDR`, the slave pulls SDA low for the whole ninth clock. If they differ, the slave does not acknowledge, sets no interrupt and leaves both lines free until the next START.
- R3: On an address match, status bit 1 (address matched) is set and control bit 0 (transmit direction) takes the value of the read/write bit.
- R4: After the falling edge of the ninth clock of every acknowledged address byte and every data byte, `scl_oe_o` goes to 1 and stays there. At the same point status bit 2, the interrupt flag, is set and `irq_o` is 1.
- R5: When control bit 0 is 0 (receive), a read of the data register (host address 0) releases SCL. A write of the data register leaves SCL held.
- R6: When control bit 0 is 1 (transmit), a write of the data register releases SCL and the written byte goes out on SDA MSB first. A read of the data register leaves SCL held.
- R7: In receive direction, each data byte is acknowledged by pulling SDA low on its ninth clock, and the byte can then be read from the data register.
- R8: In transmit direction, the level the master puts on SDA during the ninth clock is stored in status bit 0 (1 means not-acknowledge).
- R9: After a not-acknowledge, a dummy read without a direction change leaves SCL held. Writing control bit 0 to 0 and then reading the data register releases SCL, so a STOP from the master can complete.
- R10: Writing 1 to status bit 2 clears the interrupt flag. Writing 0 to it leaves the flag as it is.
- R11: A STOP or a repeated START puts the slave back to idle, releases both lines and clears status bit 1. A repeated START also begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level, already synchronised to `clk` |
| sda_i | input | 1 | Bus data line level, already synchronised to `clk` |
| scl_oe_o | output | 1 | Pull-down enable for the clock line (1 holds SCL low) |
| sda_oe_o | output | 1 | Pull-down enable for the data line (1 drives SDA low) |
| host_wr_i | input | 1 | Host write strobe, one cycle long |
| host_rd_i | input | 1 | Host read strobe, one cycle long |
| host_addr_i | input | REG_AW | Host register address: 0 data, 1 control, 2 status |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, combinational from `host_addr_i` |
| irq_o | output | 1 | Interrupt request, the same as status bit 2 |

## Verification
The hardest state to reach from the ports is the end of a master read that finished with a not-acknowledge. To get there, the bench has to act as both the master and the host, interleaved. The master's clock release must wait on the wired-AND line while the host runs its accesses against the held clock. The bench first does a dummy read while still in transmit direction and checks that the clock stays held. Only then does it switch direction, read again, and let the master's STOP complete. Wrong-kind accesses and a repeated START after a received byte are driven the same way, each with the resulting line state checked before the next master action.

// File: rtl/i2c_ss_pkg.sv
package i2c_ss_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;

    localparam int STAT_RXACK = 0;
    localparam int STAT_MATCH = 1;
    localparam int STAT_IRQ   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HOLD,
        ST_RX_BITS,
        ST_RX_ACK,
        ST_TX_BITS,
        ST_TX_ACK
    } eng_state_e;

    typedef struct packed {
        eng_state_e        st;
        logic              skip;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              sda_oe;
    } eng_regs_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              tx_mode;
        logic              rxack;
        logic              amatch;
        logic              irq;
    } host_regs_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_regs_t;

endpackage

// File: rtl/i2c_ss_line_mon.sv
module i2c_ss_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    import i2c_ss_pkg::*;

    line_regs_t lm_d, lm_q;

    always_comb begin
        lm_d.scl   = scl_i;
        lm_d.sda   = sda_i;
        scl_rise_o = !lm_q.scl && scl_i;
        scl_fall_o = lm_q.scl && !scl_i;
        start_o    = lm_q.scl && scl_i && lm_q.sda && !sda_i;
        stop_o     = lm_q.scl && scl_i && !lm_q.sda && sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lm_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            lm_q <= lm_d;
        end
    end

    // A bus condition is only seen while the clock line is high on both samples.
    assert_cond_needs_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o || stop_o) |-> (scl_i && $past(scl_i)));

endmodule

// File: rtl/i2c_ss_engine.sv
module i2c_ss_engine #(
    parameter int               ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h42
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sda_i,
    input  logic                          scl_i,
    input  logic                          scl_rise_i,
    input  logic                          scl_fall_i,
    input  logic                          start_i,
    input  logic                          stop_i,
    input  logic                          tx_mode_i,
    input  logic                          data_wr_i,
    input  logic                          data_rd_i,
    input  logic [i2c_ss_pkg::BYTE_W-1:0] wdata_i,
    output logic                          scl_oe_o,
    output logic                          sda_oe_o,
    output logic                          ev_addr_o,
    output logic                          ev_rw_o,
    output logic                          ev_rx_o,
    output logic [i2c_ss_pkg::BYTE_W-1:0] rx_byte_o,
    output logic                          ev_ack_o,
    output logic                          ack_bit_o,
    output logic                          ev_end_o,
    output logic                          ev_idle_o
);
    import i2c_ss_pkg::*;

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    eng_regs_t en_d, en_q;
    logic      addr_hit;

    assign addr_hit  = (en_q.sh[BYTE_W-1 -: ADDR_W] == OWN_ADDR);
    assign scl_oe_o  = (en_q.st == ST_HOLD);
    assign sda_oe_o  = en_q.sda_oe;
    assign rx_byte_o = en_q.sh;
    assign ev_rw_o   = en_q.sh[0];
    assign ack_bit_o = sda_i;

    always_comb begin
        en_d      = en_q;
        ev_addr_o = 1'b0;
        ev_rx_o   = 1'b0;
        ev_ack_o  = 1'b0;
        ev_end_o  = 1'b0;
        ev_idle_o = 1'b0;
        if (stop_i) begin
            en_d.st     = ST_IDLE;
            en_d.sda_oe = 1'b0;
            ev_idle_o   = 1'b1;
        end else if (start_i) begin
            en_d.st     = ST_ADDR;
            en_d.skip   = 1'b0;
            en_d.cnt    = '0;
            en_d.sda_oe = 1'b0;
            ev_idle_o   = 1'b1;
        end else begin
            unique case (en_q.st)
                ST_IDLE: begin
                end
                ST_ADDR: begin
                    if (en_q.skip) begin
                        en_d.st = ST_ADDR;
                    end else if (scl_rise_i) begin
                        en_d.sh  = {en_q.sh[BYTE_W-2:0], sda_i};
                        en_d.cnt = en_q.cnt + 1'b1;
                    end else if (scl_fall_i && en_q.cnt == LAST_BIT) begin
                        if (addr_hit) begin
                            en_d.st     = ST_ADDR_ACK;
                            en_d.sda_oe = 1'b1;
                        end else begin
                            en_d.skip = 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        en_d.sda_oe = 1'b0;
                        en_d.st     = ST_HOLD;
                        ev_addr_o   = 1'b1;
                        ev_end_o    = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (tx_mode_i && data_wr_i) begin
                        en_d.sh     = wdata_i;
                        en_d.sda_oe = !wdata_i[BYTE_W-1];
                        en_d.cnt    = '0;
                        en_d.st     = ST_TX_BITS;
                    end else if (!tx_mode_i && data_rd_i) begin
                        en_d.cnt = '0;
                        en_d.st  = ST_RX_BITS;
                    end
                end
                ST_RX_BITS: begin
                    if (scl_rise_i) begin
                        en_d.sh  = {en_q.sh[BYTE_W-2:0], sda_i};
                        en_d.cnt = en_q.cnt + 1'b1;
                    end else if (scl_fall_i && en_q.cnt == LAST_BIT) begin
                        ev_rx_o     = 1'b1;
                        en_d.sda_oe = 1'b1;
                        en_d.st     = ST_RX_ACK;
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall_i) begin
                        en_d.sda_oe = 1'b0;
                        en_d.st     = ST_HOLD;
                        ev_end_o    = 1'b1;
                    end
                end
                ST_TX_BITS: begin
                    if (scl_rise_i) begin
                        en_d.cnt = en_q.cnt + 1'b1;
                    end else if (scl_fall_i) begin
                        if (en_q.cnt == LAST_BIT) begin
                            en_d.sda_oe = 1'b0;
                            en_d.st     = ST_TX_ACK;
                        end else begin
                            en_d.sh     = {en_q.sh[BYTE_W-2:0], 1'b0};
                            en_d.sda_oe = !en_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise_i) begin
                        ev_ack_o = 1'b1;
                    end else if (scl_fall_i) begin
                        en_d.st  = ST_HOLD;
                        ev_end_o = 1'b1;
                    end
                end
                default: en_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '{st: ST_IDLE, skip: 1'b0, sh: '0, cnt: '0, sda_oe: 1'b0};
        end else begin
            en_q <= en_d;
        end
    end

    assert_rx_wrong_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q.st == ST_HOLD && !tx_mode_i && !data_rd_i) |=> scl_oe_o);

    assert_tx_wrong_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q.st == ST_HOLD && tx_mode_i && !data_wr_i) |=> scl_oe_o);

    // SDA is only pulled low while the clock line is low.
    assert_sda_low_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    assert_stop_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!scl_oe_o && !sda_oe_o && en_q.st == ST_IDLE));

    assert_mismatch_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_q.skip |-> (!sda_oe_o && !scl_oe_o));

endmodule

// File: rtl/i2c_ss_hostif.sv
module i2c_ss_hostif #(
    parameter int REG_AW = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_wr_i,
    input  logic                          host_rd_i,
    input  logic [REG_AW-1:0]             host_addr_i,
    input  logic [i2c_ss_pkg::BYTE_W-1:0] host_wdata_i,
    output logic [i2c_ss_pkg::BYTE_W-1:0] host_rdata_o,
    output logic                          irq_o,
    output logic                          tx_mode_o,
    output logic                          data_wr_o,
    output logic                          data_rd_o,
    input  logic                          ev_addr_i,
    input  logic                          ev_rw_i,
    input  logic                          ev_rx_i,
    input  logic [i2c_ss_pkg::BYTE_W-1:0] rx_byte_i,
    input  logic                          ev_ack_i,
    input  logic                          ack_bit_i,
    input  logic                          ev_end_i,
    input  logic                          ev_idle_i
);
    import i2c_ss_pkg::*;

    host_regs_t hr_d, hr_q;
    logic       sel_data, sel_ctrl, sel_stat;
    logic       stat_clr;

    assign sel_data  = (host_addr_i == REG_AW'(REG_DATA));
    assign sel_ctrl  = (host_addr_i == REG_AW'(REG_CTRL));
    assign sel_stat  = (host_addr_i == REG_AW'(REG_STAT));
    assign data_wr_o = host_wr_i && sel_data;
    assign data_rd_o = host_rd_i && sel_data;
    assign stat_clr  = host_wr_i && sel_stat && host_wdata_i[STAT_IRQ];
    assign irq_o     = hr_q.irq;
    assign tx_mode_o = hr_q.tx_mode;

    always_comb begin
        hr_d = hr_q;
        if (data_wr_o) hr_d.data = host_wdata_i;
        if (host_wr_i && sel_ctrl) hr_d.tx_mode = host_wdata_i[0];
        if (stat_clr) hr_d.irq = 1'b0;
        if (ev_addr_i) begin
            hr_d.tx_mode = ev_rw_i;
            hr_d.amatch  = 1'b1;
        end
        if (ev_idle_i) hr_d.amatch = 1'b0;
        if (ev_rx_i) hr_d.data = rx_byte_i;
        if (ev_ack_i) hr_d.rxack = ack_bit_i;
        if (ev_end_i) hr_d.irq = 1'b1;
    end

    always_comb begin
        host_rdata_o = '0;
        if (sel_data) begin
            host_rdata_o = hr_q.data;
        end else if (sel_ctrl) begin
            host_rdata_o[0] = hr_q.tx_mode;
        end else if (sel_stat) begin
            host_rdata_o[STAT_RXACK] = hr_q.rxack;
            host_rdata_o[STAT_MATCH] = hr_q.amatch;
            host_rdata_o[STAT_IRQ]   = hr_q.irq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hr_q <= '0;
        end else begin
            hr_q <= hr_d;
        end
    end

    assert_irq_from_byte_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(ev_end_i));

    assert_irq_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !ev_end_i) |=> !irq_o);

    assert_rxack_only_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_ack_i |=> $stable(hr_q.rxack));

endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave #(
    parameter int                ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h42,
    parameter int                REG_AW   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    input  logic              host_wr_i,
    input  logic              host_rd_i,
    input  logic [REG_AW-1:0] host_addr_i,
    input  logic [7:0]        host_wdata_i,
    output logic [7:0]        host_rdata_o,
    output logic              irq_o
);
    import i2c_ss_pkg::*;

    logic              scl_rise, scl_fall, cond_start, cond_stop;
    logic              tx_mode, data_wr, data_rd;
    logic              ev_addr, ev_rw, ev_rx, ev_ack, ack_bit, ev_end, ev_idle;
    logic [BYTE_W-1:0] rx_byte;

    i2c_ss_line_mon u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (cond_start),
        .stop_o     (cond_stop)
    );

    i2c_ss_engine #(
        .ADDR_W   (ADDR_W),
        .OWN_ADDR (OWN_ADDR)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_i),
        .scl_i      (scl_i),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (cond_start),
        .stop_i     (cond_stop),
        .tx_mode_i  (tx_mode),
        .data_wr_i  (data_wr),
        .data_rd_i  (data_rd),
        .wdata_i    (host_wdata_i),
        .scl_oe_o   (scl_oe_o),
        .sda_oe_o   (sda_oe_o),
        .ev_addr_o  (ev_addr),
        .ev_rw_o    (ev_rw),
        .ev_rx_o    (ev_rx),
        .rx_byte_o  (rx_byte),
        .ev_ack_o   (ev_ack),
        .ack_bit_o  (ack_bit),
        .ev_end_o   (ev_end),
        .ev_idle_o  (ev_idle)
    );

    i2c_ss_hostif #(
        .REG_AW (REG_AW)
    ) u_host (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_i    (host_wr_i),
        .host_rd_i    (host_rd_i),
        .host_addr_i  (host_addr_i),
        .host_wdata_i (host_wdata_i),
        .host_rdata_o (host_rdata_o),
        .irq_o        (irq_o),
        .tx_mode_o    (tx_mode),
        .data_wr_o    (data_wr),
        .data_rd_o    (data_rd),
        .ev_addr_i    (ev_addr),
        .ev_rw_i      (ev_rw),
        .ev_rx_i      (ev_rx),
        .rx_byte_i    (rx_byte),
        .ev_ack_i     (ev_ack),
        .ack_bit_i    (ack_bit),
        .ev_end_i     (ev_end),
        .ev_idle_i    (ev_idle)
    );

endmodule

// File: tb/i2c_stretch_slave_tb.sv
module i2c_stretch_slave_tb;

    localparam logic [6:0] MY_ADDR = 7'h42;
    localparam int         HQ      = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       scl_oe, sda_oe, scl_line, sda_line;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       irq;
    int         n_checks = 0;
    int         n_fails  = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    i2c_stretch_slave #(.OWN_ADDR(MY_ADDR)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_line),
        .sda_i        (sda_line),
        .scl_oe_o     (scl_oe),
        .sda_oe_o     (sda_oe),
        .host_wr_i    (host_wr),
        .host_rd_i    (host_rd),
        .host_addr_i  (host_addr),
        .host_wdata_i (host_wdata),
        .host_rdata_o (host_rdata),
        .irq_o        (irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        wait_clk(2);
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #5 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
        wait_clk(2);
    endtask

    task automatic scl_release();
        m_scl_low = 1'b0;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
        wait_clk(HQ);
    endtask

    task automatic m_start();
        m_sda_low = 1'b1; wait_clk(HQ);
        m_scl_low = 1'b1; wait_clk(HQ);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; wait_clk(HQ);
        scl_release();
        m_sda_low = 1'b0; wait_clk(HQ);
    endtask

    task automatic m_rstart();
        m_sda_low = 1'b0; wait_clk(HQ);
        scl_release();
        m_sda_low = 1'b1; wait_clk(HQ);
        m_scl_low = 1'b1; wait_clk(HQ);
    endtask

    task automatic m_put_bit(input logic b);
        m_sda_low = !b; wait_clk(HQ);
        scl_release();
        m_scl_low = 1'b1; wait_clk(HQ);
    endtask

    task automatic m_get_bit(output logic b);
        m_sda_low = 1'b0; wait_clk(HQ);
        m_scl_low = 1'b0;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
        wait_clk(HQ / 2);
        b = sda_line;
        wait_clk(HQ / 2);
        m_scl_low = 1'b1; wait_clk(HQ);
    endtask

    task automatic m_write_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) m_put_bit(v[i]);
        m_get_bit(b);
        acked = !b;
    endtask

    task automatic m_read_byte(input logic nack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_get_bit(b);
            v[i] = b;
        end
        m_put_bit(nack);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        check("R1", "scl_oe", scl_oe, 0);
        check("R1", "sda_oe", sda_oe, 0);
        check("R1", "irq", irq, 0);
        host_read(2'd2, r); check("R1", "status", r, 8'h00);
        host_read(2'd1, r); check("R1", "control", r, 8'h00);
    endtask

    task automatic t_master_write();
        logic a;
        logic [7:0] r;
        m_start();
        m_write_byte({MY_ADDR, 1'b0}, a);
        check("R2", "address ack", a, 1);
        host_read(2'd2, r); check("R3", "match bit", r[1], 1);
        host_read(2'd1, r); check("R3", "direction rx", r[0], 0);
        check("R4", "scl held after address", scl_oe, 1);
        check("R4", "irq after address", irq, 1);
        host_write(2'd0, 8'h77); wait_clk(10);
        check("R5", "write in rx keeps scl held", scl_oe, 1);
        host_write(2'd2, 8'h00);
        check("R10", "write 0 keeps irq", irq, 1);
        host_write(2'd2, 8'h04);
        check("R10", "write 1 clears irq", irq, 0);
        host_read(2'd0, r);
        check("R5", "read in rx releases scl", scl_oe, 0);
        m_write_byte(8'hA5, a);
        check("R7", "data ack", a, 1);
        check("R4", "scl held after data", scl_oe, 1);
        check("R4", "irq after data", irq, 1);
        host_read(2'd0, r);
        check("R7", "received byte 1", r, 8'hA5);
        host_write(2'd2, 8'h04);
        m_write_byte(8'h3C, a);
        check("R7", "second ack", a, 1);
        host_read(2'd0, r);
        check("R7", "received byte 2", r, 8'h3C);
        m_stop();
        check("R11", "scl free after stop", scl_oe, 0);
        check("R11", "sda free after stop", sda_oe, 0);
        host_read(2'd2, r); check("R11", "match cleared", r[1], 0);
        host_write(2'd2, 8'h04);
    endtask

    task automatic t_master_read();
        logic a;
        logic [7:0] r, v;
        m_start();
        m_write_byte({MY_ADDR, 1'b1}, a);
        check("R2", "read address ack", a, 1);
        host_read(2'd1, r); check("R3", "direction tx", r[0], 1);
        host_read(2'd0, r); wait_clk(10);
        check("R6", "read in tx keeps scl held", scl_oe, 1);
        host_write(2'd0, 8'h96);
        check("R6", "write in tx releases scl", scl_oe, 0);
        m_read_byte(1'b0, v);
        check("R6", "sent byte 1", v, 8'h96);
        host_read(2'd2, r); check("R8", "ack captured", r[0], 0);
        check("R4", "scl held after tx byte", scl_oe, 1);
        host_write(2'd0, 8'h5A);
        m_read_byte(1'b1, v);
        check("R6", "sent byte 2", v, 8'h5A);
        host_read(2'd2, r); check("R8", "nack captured", r[0], 1);
        host_read(2'd0, r); wait_clk(10);
        check("R9", "dummy read without mode change", scl_oe, 1);
        host_write(2'd1, 8'h00);
        host_read(2'd0, r);
        check("R9", "mode change plus dummy read", scl_oe, 0);
        m_stop();
        check("R9", "idle after stop scl", scl_oe, 0);
        check("R9", "idle after stop sda", sda_oe, 0);
        host_write(2'd2, 8'h04);
    endtask

    task automatic t_mismatch();
        logic a;
        logic [7:0] r;
        m_start();
        m_write_byte({7'h13, 1'b0}, a);
        check("R2", "foreign address not acked", a, 0);
        check("R2", "no irq for foreign address", irq, 0);
        check("R2", "scl free for foreign address", scl_oe, 0);
        m_write_byte(8'hFF, a);
        check("R2", "foreign data not acked", a, 0);
        host_read(2'd2, r); check("R2", "no match bit", r[1], 0);
        m_stop();
    endtask

    task automatic t_restart();
        logic a;
        logic [7:0] r, v;
        m_start();
        m_write_byte({MY_ADDR, 1'b0}, a);
        host_read(2'd0, r);
        m_write_byte(8'h81, a);
        host_read(2'd0, r);
        check("R7", "byte before restart", r, 8'h81);
        m_rstart();
        check("R11", "scl free after restart", scl_oe, 0);
        host_read(2'd2, r); check("R11", "match cleared by restart", r[1], 0);
        m_write_byte({MY_ADDR, 1'b1}, a);
        check("R11", "new address phase acked", a, 1);
        host_read(2'd1, r); check("R3", "direction after restart", r[0], 1);
        host_write(2'd0, 8'hC3);
        m_read_byte(1'b1, v);
        check("R6", "byte after restart", v, 8'hC3);
        host_write(2'd1, 8'h00);
        host_read(2'd0, r);
        m_stop();
        check("R11", "idle sda", sda_oe, 0);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_master_write();
        t_master_read();
        t_mismatch();
        t_restart();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule